// File: doc/BRIEF.md
# Program Cache Line Valid Tracker

This block keeps the bookkeeping for a small on-chip instruction cache of 512 bytes, organised as 32 lines of 16 bytes. The cache covers one contiguous window of program space that starts at a 16-byte aligned base. The block holds that base, one valid bit per line and a flag that says whether the cache is in use. It has no per-line tags. The cache data storage, the engine that fills it from program memory and the instruction decoder all sit outside this block.

The fill logic reports each byte it writes as a strobe with a 9-bit cache-relative address. A line counts as valid once its final byte (offset 15) has been written. Any cache write also turns the cache on. A flush command empties the tracker and turns the cache off. A base-load command moves the window. If the aligned base actually changes, the old contents are dropped. The fetch side presents a 16-bit program counter and gets back a combinational hit that says whether the counter lies inside the active window.

Top module: `prog_cache_valid_tracker`

## Requirements
- R1: While rst_ni is low, valid_o is zero, active_o is 0 and hit_o is 0.
- R2: A cache write whose address bits [3:0] are 4'hF sets valid_o bit n, where n is address bits [8:4]. The bit is visible one clock after the strobe.
- R3: A cache write whose address bits [3:0] are not 4'hF leaves valid_o unchanged.
- R4: Every cache write, whatever its offset, sets active_o one clock later.
- R5: A flush clears all of valid_o, clears active_o and sets the base to 0x0000. All three take effect one clock later.
- R6: When a flush arrives in the same cycle as a write or a base load, the flush wins. The write sets no bit and does not activate the cache, and the base ends at 0x0000.
- R7: A loaded base has bits [3:0] forced to zero.
- R8: Loading a base whose aligned value equals the current base leaves valid_o unchanged.
- R9: Loading a base whose aligned value differs clears valid_o. A line-completing write in the same cycle still sets its own bit.
- R10: hit_o is 1 exactly when active_o is 1 and base <= pc_i < base + 512.
- R11: The upper window bound is computed with 17 bits, so a window near 0xFFFF does not wrap around to low addresses.
- R12: While active_o is 0, hit_o is 0 for every pc_i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Cache byte write strobe |
| wr_addr_i | input | 9 | Cache-relative address of the written byte |
| flush_i | input | 1 | Flush command |
| base_ld_i | input | 1 | Base load command |
| base_i | input | 16 | New cache base; bits [3:0] are ignored |
| pc_i | input | 16 | Program counter for the hit query |
| valid_o | output | 32 | Per-line valid bits |
| active_o | output | 1 | Cache in use |
| hit_o | output | 1 | pc_i lies inside the active window |

## Verification
A corrupted valid bit appears on valid_o at the clock edge right after the write, flush or base load that caused it. A wrong base register or active flag cannot be seen directly. It shows up only as a wrong hit_o, in the same cycle that pc_i probes the affected window edge. For that reason the stimulus walks pc_i across both edges of every base it loads, including a base near the top of the address space. A missed clear on a base change would leave stale bits on valid_o one cycle after the load. Same-cycle collisions of flush, write and load are driven on purpose, because a wrong priority would show up only then.

// File: rtl/pcv_pkg.sv
package pcv_pkg;
  // Per-cycle action applied to the valid vector
  typedef enum logic [1:0] {
    VA_KEEP  = 2'd0,  // retain old bits, OR in new line
    VA_SWAP  = 2'd1,  // base moved: drop old bits, keep new line
    VA_WIPE  = 2'd2   // flush: everything cleared
  } valid_act_e;
endpackage

// File: rtl/pcv_base_ctrl.sv
module pcv_base_ctrl
  import pcv_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              base_ld_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              wr_en_i,
  output logic [ADDR_W-1:0] base_o,
  output logic              active_o,
  output valid_act_e        act_o
);
  logic [ADDR_W-1:0] base_q, base_aligned;
  logic              active_q;
  logic              base_moves;

  assign base_aligned = {base_i[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign base_moves   = base_ld_i && (base_aligned != base_q);

  always_comb begin
    if (flush_i)         act_o = VA_WIPE;
    else if (base_moves) act_o = VA_SWAP;
    else                 act_o = VA_KEEP;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q   <= '0;
      active_q <= 1'b0;
    end else if (flush_i) begin
      base_q   <= '0;
      active_q <= 1'b0;
    end else begin
      if (base_ld_i) base_q   <= base_aligned;
      if (wr_en_i)   active_q <= 1'b1;
    end
  end

  assign base_o   = base_q;
  assign active_o = active_q;
endmodule

// File: rtl/pcv_valid_vec.sv
module pcv_valid_vec
  import pcv_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int OFF_W     = 4,
  parameter int IDX_W     = 5
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic [IDX_W+OFF_W-1:0] wr_addr_i,
  input  valid_act_e             act_i,
  output logic [NUM_LINES-1:0]   valid_o
);
  logic [IDX_W-1:0] line_idx;
  logic             line_done;

  assign line_idx  = wr_addr_i[IDX_W+OFF_W-1:OFF_W];
  assign line_done = wr_en_i && (wr_addr_i[OFF_W-1:0] == {OFF_W{1'b1}});

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic set_g;
    logic vld_q;
    assign set_g = line_done && (line_idx == IDX_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) vld_q <= 1'b0;
      else begin
        unique case (act_i)
          VA_WIPE: vld_q <= 1'b0;
          VA_SWAP: vld_q <= set_g;
          default: vld_q <= vld_q | set_g;
        endcase
      end
    end
    assign valid_o[g] = vld_q;
  end
endmodule

// File: rtl/pcv_window_cmp.sv
module pcv_window_cmp #(
  parameter int ADDR_W      = 16,
  parameter int CACHE_BYTES = 512
) (
  input  logic              active_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] pc_i,
  output logic              hit_o
);
  logic [ADDR_W:0] limit;
  logic            above_lo, below_hi;

  // One extra bit keeps a top-of-space window from wrapping
  assign limit    = {1'b0, base_i} + (ADDR_W+1)'(CACHE_BYTES);
  assign above_lo = pc_i >= base_i;
  assign below_hi = {1'b0, pc_i} < limit;
  assign hit_o    = active_i && above_lo && below_hi;
endmodule

// File: rtl/prog_cache_valid_tracker.sv
module prog_cache_valid_tracker
  import pcv_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int LINE_BYTES = 16,
  parameter int NUM_LINES  = 32,
  localparam int OFF_W       = $clog2(LINE_BYTES),
  localparam int IDX_W       = $clog2(NUM_LINES),
  localparam int CADDR_W     = OFF_W + IDX_W,
  localparam int CACHE_BYTES = LINE_BYTES * NUM_LINES
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [CADDR_W-1:0]   wr_addr_i,
  input  logic                 flush_i,
  input  logic                 base_ld_i,
  input  logic [ADDR_W-1:0]    base_i,
  input  logic [ADDR_W-1:0]    pc_i,
  output logic [NUM_LINES-1:0] valid_o,
  output logic                 active_o,
  output logic                 hit_o
);
  logic [ADDR_W-1:0] base_q;
  valid_act_e        act;

  pcv_base_ctrl #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_base (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .flush_i   (flush_i),
    .base_ld_i (base_ld_i),
    .base_i    (base_i),
    .wr_en_i   (wr_en_i),
    .base_o    (base_q),
    .active_o  (active_o),
    .act_o     (act)
  );

  pcv_valid_vec #(.NUM_LINES(NUM_LINES), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_vld (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .act_i     (act),
    .valid_o   (valid_o)
  );

  pcv_window_cmp #(.ADDR_W(ADDR_W), .CACHE_BYTES(CACHE_BYTES)) u_win (
    .active_i (active_o),
    .base_i   (base_q),
    .pc_i     (pc_i),
    .hit_o    (hit_o)
  );
endmodule

// File: rtl/pcv_checker.sv
module pcv_checker #(
  parameter int NUM_LINES = 32,
  parameter int OFF_W     = 4,
  parameter int CADDR_W   = 9
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 wr_en_i,
  input logic [CADDR_W-1:0]   wr_addr_i,
  input logic                 flush_i,
  input logic                 base_ld_i,
  input logic [NUM_LINES-1:0] valid_o,
  input logic                 active_o,
  input logic                 hit_o
);
  AST_FLUSH_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (valid_o == '0) && !active_o); // R5

  AST_WRITE_ACTIVATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !flush_i |=> active_o); // R4

  AST_PARTIAL_NO_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !flush_i && !base_ld_i && (wr_addr_i[OFF_W-1:0] != {OFF_W{1'b1}})
    |=> valid_o == $past(valid_o)); // R3

  AST_LINE_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !flush_i && (wr_addr_i[OFF_W-1:0] == {OFF_W{1'b1}})
    |=> valid_o[$past(wr_addr_i[CADDR_W-1:OFF_W])]); // R2

  AST_NO_SPONTANEOUS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flush_i && !base_ld_i |=> (valid_o & $past(valid_o)) == $past(valid_o)); // R8

  AST_FLUSH_BEATS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i && wr_en_i |=> !active_o); // R6

  AST_HIT_NEEDS_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> active_o); // R12
endmodule

bind prog_cache_valid_tracker pcv_checker #(
  .NUM_LINES(NUM_LINES), .OFF_W(OFF_W), .CADDR_W(CADDR_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .flush_i   (flush_i),
  .base_ld_i (base_ld_i),
  .valid_o   (valid_o),
  .active_o  (active_o),
  .hit_o     (hit_o)
);

// File: tb/prog_cache_valid_tracker_tb.sv
`timescale 1ns/1ps
module prog_cache_valid_tracker_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [8:0]  wr_addr_i = '0;
  logic        flush_i = 1'b0;
  logic        base_ld_i = 1'b0;
  logic [15:0] base_i = '0;
  logic [15:0] pc_i = '0;
  logic [31:0] valid_o;
  logic        active_o;
  logic        hit_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  prog_cache_valid_tracker u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .flush_i(flush_i), .base_ld_i(base_ld_i), .base_i(base_i), .pc_i(pc_i),
    .valid_o(valid_o), .active_o(active_o), .hit_o(hit_o)
  );

  typedef struct packed {
    logic        fl;
    logic        wr;
    logic [8:0]  wa;
    logic        ld;
    logic [15:0] base;
    logic [15:0] pc;
    logic [31:0] ev;
    logic        ea;
    logic        eh;
    logic [23:0] tag;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b1, 9'h00F, 1'b0, 16'h0000, 16'h0000, 32'h0000_0001, 1'b1, 1'b1, "R2 "},
    '{1'b0, 1'b1, 9'h1F5, 1'b0, 16'h0000, 16'h01FF, 32'h0000_0001, 1'b1, 1'b1, "R3 "},
    '{1'b0, 1'b1, 9'h1FF, 1'b0, 16'h0000, 16'h0200, 32'h8000_0001, 1'b1, 1'b0, "R10"},
    '{1'b0, 1'b0, 9'h000, 1'b1, 16'h0000, 16'h0100, 32'h8000_0001, 1'b1, 1'b1, "R8 "},
    '{1'b0, 1'b0, 9'h000, 1'b1, 16'h1237, 16'h1230, 32'h0000_0000, 1'b1, 1'b1, "R9 "},
    '{1'b0, 1'b0, 9'h000, 1'b0, 16'h0000, 16'h122F, 32'h0000_0000, 1'b1, 1'b0, "R7 "},
    '{1'b0, 1'b0, 9'h000, 1'b0, 16'h0000, 16'h142F, 32'h0000_0000, 1'b1, 1'b1, "R10"},
    '{1'b0, 1'b0, 9'h000, 1'b0, 16'h0000, 16'h1430, 32'h0000_0000, 1'b1, 1'b0, "R10"},
    '{1'b0, 1'b1, 9'h03F, 1'b1, 16'h1238, 16'h1235, 32'h0000_0008, 1'b1, 1'b1, "R8 "},
    '{1'b0, 1'b1, 9'h05F, 1'b1, 16'h2000, 16'h2000, 32'h0000_0020, 1'b1, 1'b1, "R9 "},
    '{1'b1, 1'b1, 9'h0FF, 1'b1, 16'h3000, 16'h0000, 32'h0000_0000, 1'b0, 1'b0, "R6 "},
    '{1'b0, 1'b0, 9'h000, 1'b0, 16'h0000, 16'h0000, 32'h0000_0000, 1'b0, 1'b0, "R12"},
    '{1'b0, 1'b1, 9'h000, 1'b0, 16'h0000, 16'h0000, 32'h0000_0000, 1'b1, 1'b1, "R5 "},
    '{1'b0, 1'b0, 9'h000, 1'b1, 16'hFF05, 16'hFFFF, 32'h0000_0000, 1'b1, 1'b1, "R11"},
    '{1'b0, 1'b0, 9'h000, 1'b0, 16'h0000, 16'h0000, 32'h0000_0000, 1'b1, 1'b0, "R11"},
    '{1'b0, 1'b0, 9'h000, 1'b0, 16'h0000, 16'h00FF, 32'h0000_0000, 1'b1, 1'b0, "R11"},
    '{1'b0, 1'b0, 9'h000, 1'b0, 16'h0000, 16'hFEFF, 32'h0000_0000, 1'b1, 1'b0, "R10"},
    '{1'b1, 1'b0, 9'h000, 1'b0, 16'h0000, 16'h0010, 32'h0000_0000, 1'b0, 1'b0, "R5 "}
  };

  task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic idle();
    wr_en_i = 1'b0; flush_i = 1'b0; base_ld_i = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk_i);
    chk("R1", "valid in reset", valid_o, 32'h0);
    chk("R1", "active in reset", {31'b0, active_o}, 32'h0);
    chk("R1", "hit in reset", {31'b0, hit_o}, 32'h0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      flush_i = VEC[i].fl; wr_en_i = VEC[i].wr; wr_addr_i = VEC[i].wa;
      base_ld_i = VEC[i].ld; base_i = VEC[i].base; pc_i = VEC[i].pc;
      @(posedge clk_i);
      @(negedge clk_i);
      idle();
      chk($sformatf("%s", VEC[i].tag), $sformatf("vec %0d valid", i), valid_o, VEC[i].ev);
      chk($sformatf("%s", VEC[i].tag), $sformatf("vec %0d active", i), {31'b0, active_o}, {31'b0, VEC[i].ea});
      chk($sformatf("%s", VEC[i].tag), $sformatf("vec %0d hit", i), {31'b0, hit_o}, {31'b0, VEC[i].eh});
    end

    // R2: fill every line in turn
    for (int n = 0; n < 32; n++) begin
      wr_en_i = 1'b1; wr_addr_i = {n[4:0], 4'hF};
      @(posedge clk_i);
      @(negedge clk_i);
      idle();
      chk("R2", $sformatf("line %0d fill", n), valid_o, (n == 31) ? 32'hFFFF_FFFF : ((32'h1 << (n + 1)) - 32'h1));
    end

    // R12: pc inside window of base 0 while inactive after flush
    flush_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    idle();
    pc_i = 16'h0080;
    #0.5;
    chk("R12", "hit while inactive", {31'b0, hit_o}, 32'h0);

    // R1: asynchronous reset in mid-run
    wr_en_i = 1'b1; wr_addr_i = 9'h0AF;
    @(posedge clk_i);
    @(negedge clk_i);
    idle();
    chk("R2", "line 10 before reset", valid_o, 32'h0000_0400);
    rst_ni = 1'b0;
    #0.5;
    chk("R1", "valid after async reset", valid_o, 32'h0);
    chk("R1", "active after async reset", {31'b0, active_o}, 32'h0);
    chk("R1", "hit after async reset", {31'b0, hit_o}, 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule